// File: doc/BRIEF.md
# Coprocessor Response Dialog Sequencer

This block runs the main-processor side of a coprocessor dialog. When a coprocessor instruction starts, the sequencer polls the coprocessor's response register over a simple register bus and receives a 16-bit response word. It decodes the attribute bits and the function field of that word. If the coprocessor asks for it, the sequencer first writes the address of the instruction's operation word into the coprocessor's instruction-address register. It then hands any real service request to the surrounding core through a request/acknowledge handshake.

The come-again attribute sends the sequencer back to read the response register once the service is done. Without that attribute the dialog ends. A release word (null function, come-again clear) always ends the dialog. A null word with come-again set means the coprocessor is still busy, and the sequencer polls again without requesting any service.

When tracing is enabled, the sequencer does not report the end of the instruction until the coprocessor has actually released it. A programmable poll limit bounds the number of response reads in a dialog. Function codes outside the supported set end the dialog with a protocol error.

Top module: `cp_dialog_seq`

## Requirements
- R1: While and after a synchronous reset, bus_req, svc_req, done, err, trace_take and busy are all low.
- R2: A start pulse in idle begins a dialog with a response-register read: bus_req=1, bus_we=0, bus_sel=0. Every bus access keeps bus_req, bus_we and bus_sel unchanged until the cycle in which bus_ready is high.
- R3: If bit 14 of the response word is set, the next access is a write with bus_sel=1, and bus_wdata equals the op_addr value captured at start. This write comes before any service request for that word.
- R4: The function field is bits 12:8, and code 0x08 is null. A null word with bit 15 clear ends the dialog with a one-cycle done pulse. A null word with bit 15 set causes another response read with no service request.
- R5: For the supported non-null codes 0x0C, 0x0D, 0x10, 0x11 and 0x1C, svc_req rises with svc_prim equal to bits 13:0 of the word. The request is held until svc_ack.
- R6: After a service, bit 15 set causes another response read. Bit 15 clear ends the dialog with done, provided tracing is off.
- R7: A function code outside the six supported codes gives a one-cycle err pulse with err_code=1. No instruction-address write and no service follow, and the block returns to idle.
- R8: A dialog performs at most max_polls response reads, where 0 counts as 1. If another read would be needed at that point, the block gives err with err_code=2.
- R9: With trace_en high, a service word with bit 15 clear does not end the dialog. Reading continues until a null word with bit 15 clear arrives, and the resulting done pulse has trace_take high. With trace_en low, trace_take stays low.
- R10: bus_req and svc_req are never high together, and done and err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a dialog (taken in idle) |
| op_addr | input | AW | Operation-word address of the current instruction |
| max_polls | input | PW | Response-read limit per dialog (0 acts as 1) |
| trace_en | input | 1 | Trace mode active |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = response register, 1 = instruction-address register |
| bus_wdata | output | AW | Write data |
| bus_rdata | input | 16 | Read data (response word) |
| bus_ready | input | 1 | Access completes this cycle |
| svc_req | output | 1 | Service request to the core |
| svc_prim | output | 14 | Direction bit, function and parameter of the word |
| svc_ack | input | 1 | Service finished |
| busy | output | 1 | Dialog in progress |
| done | output | 1 | Dialog ended normally (one cycle) |
| trace_take | output | 1 | Trace may be taken now (with done) |
| err | output | 1 | Dialog aborted (one cycle) |
| err_code | output | 2 | 1 = unsupported code, 2 = poll limit |

## Verification
The main function is driven with distinct dialogs. A bare release separates ending from polling. Busy nulls repeated before a release show re-polling without service. A pass-address service word, with and without come-again, pins down the write order and the end condition. An unsupported code that also carries the pass-address bit shows that the error wins over the write. Poll-limit runs at several limits, including zero, separate the exact read count from an off-by-one. Trace runs with both an immediate release and a service word followed by busy nulls show that completion, rather than the end of the service, triggers the trace report. The bus and service responders vary their latency from zero to two cycles, so the hold and ordering rules are tested under several handshake timings.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int WORD_W   = 16;
    localparam int FUNC_W   = 5;
    localparam int N_SUP    = 6;

    localparam logic [FUNC_W-1:0] FN_NULL = 5'h08;

    localparam logic [FUNC_W-1:0] SUP_CODES [N_SUP] =
        '{5'h08, 5'h0C, 5'h0D, 5'h10, 5'h11, 5'h1C};

    typedef struct packed {
        logic              again;   // bit 15
        logic              pass_pc; // bit 14
        logic              dir;     // bit 13
        logic [FUNC_W-1:0] func;    // bits 12:8
        logic [7:0]        param;   // bits 7:0
    } prim_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_RESP,
        ST_PASS_PC,
        ST_SERVICE,
        ST_WAIT_SVC_ACK,
        ST_DONE,
        ST_ERROR
    } state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_UNSUP = 2'd1,
        ERR_POLL  = 2'd2
    } err_t;

    function automatic logic [13:0] svc_view(prim_t p);
        return {p.dir, p.func, p.param};
    endfunction

endpackage

// File: rtl/cpd_decode.sv
module cpd_decode
    import cpd_pkg::*;
(
    input  prim_t word,
    output logic  is_null,
    output logic  is_valid
);

    logic [N_SUP-1:0] hit;

    generate
        for (genvar i = 0; i < N_SUP; i++) begin : g_match
            assign hit[i] = (word.func == SUP_CODES[i]);
        end
    endgenerate

    assign is_valid = |hit;
    assign is_null  = (word.func == FN_NULL);

endmodule

// File: rtl/cpd_poll_ctr.sv
module cpd_poll_ctr #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [PW-1:0] max_polls,
    output logic          at_limit
);

    logic [PW-1:0] cnt;
    logic [PW-1:0] eff_max;

    assign eff_max  = (max_polls == '0) ? PW'(1) : max_polls;
    assign at_limit = (cnt >= eff_max);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + PW'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (cnt <= eff_max)) else $error("poll count beyond limit"); // R8

endmodule

// File: rtl/cp_dialog_seq.sv
module cp_dialog_seq
    import cpd_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] op_addr,
    input  logic [PW-1:0] max_polls,
    input  logic          trace_en,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_sel,
    output logic [AW-1:0] bus_wdata,
    input  logic [15:0]   bus_rdata,
    input  logic          bus_ready,
    output logic          svc_req,
    output logic [13:0]   svc_prim,
    input  logic          svc_ack,
    output logic          busy,
    output logic          done,
    output logic          trace_take,
    output logic          err,
    output logic [1:0]    err_code
);

    localparam logic SEL_RESP  = 1'b0;
    localparam logic SEL_IADDR = 1'b1;

    state_t        st;
    prim_t         prim_q;
    prim_t         rd_prim;
    logic [AW-1:0] pc_q;
    logic          null_q;
    err_t          err_q;

    logic          dec_null;
    logic          dec_valid;
    logic          at_limit;
    logic          reread;
    state_t        after_svc;

    assign rd_prim = prim_t'(bus_rdata);

    cpd_decode u_dec (
        .word     (rd_prim),
        .is_null  (dec_null),
        .is_valid (dec_valid)
    );

    cpd_poll_ctr #(.PW(PW)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (st == ST_IDLE),
        .inc       (st == ST_READ_RESP && bus_ready),
        .max_polls (max_polls),
        .at_limit  (at_limit)
    );

    // Decide what follows a finished (or skipped) service.
    always_comb begin
        reread = prim_q.again || (trace_en && !null_q);
        if (!reread)       after_svc = ST_DONE;
        else if (at_limit) after_svc = ST_ERROR;
        else               after_svc = ST_READ_RESP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            prim_q <= '0;
            pc_q   <= '0;
            null_q <= 1'b0;
            err_q  <= ERR_NONE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        pc_q  <= op_addr;
                        err_q <= ERR_NONE;
                        st    <= ST_READ_RESP;
                    end
                end
                ST_READ_RESP: begin
                    if (bus_ready) begin
                        prim_q <= rd_prim;
                        null_q <= dec_null;
                        if (!dec_valid) begin
                            err_q <= ERR_UNSUP;
                            st    <= ST_ERROR;
                        end else if (rd_prim.pass_pc) begin
                            st <= ST_PASS_PC;
                        end else begin
                            st <= ST_SERVICE;
                        end
                    end
                end
                ST_PASS_PC: begin
                    if (bus_ready) st <= ST_SERVICE;
                end
                ST_SERVICE: begin
                    if (null_q) begin
                        st <= after_svc;
                        if (after_svc == ST_ERROR) err_q <= ERR_POLL;
                    end else begin
                        st <= ST_WAIT_SVC_ACK;
                    end
                end
                ST_WAIT_SVC_ACK: begin
                    if (svc_ack) begin
                        st <= after_svc;
                        if (after_svc == ST_ERROR) err_q <= ERR_POLL;
                    end
                end
                ST_DONE:  st <= ST_IDLE;
                ST_ERROR: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign bus_req    = (st == ST_READ_RESP) || (st == ST_PASS_PC);
    assign bus_we     = (st == ST_PASS_PC);
    assign bus_sel    = (st == ST_PASS_PC) ? SEL_IADDR : SEL_RESP;
    assign bus_wdata  = (st == ST_PASS_PC) ? pc_q : '0;
    assign svc_req    = (st == ST_WAIT_SVC_ACK);
    assign svc_prim   = svc_view(prim_q);
    assign busy       = (st != ST_IDLE);
    assign done       = (st == ST_DONE);
    assign trace_take = (st == ST_DONE) && trace_en;
    assign err        = (st == ST_ERROR);
    assign err_code   = err_q;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_sel)))
        else $error("bus request dropped early"); // R2

    AST_IADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (bus_sel == SEL_IADDR && !svc_req))
        else $error("write not aimed at address register"); // R3

    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (svc_req && !svc_ack) |=> (svc_req && $stable(svc_prim)))
        else $error("service request dropped early"); // R5

    AST_UNSUP_CODE: assert property (@(posedge clk) disable iff (rst)
        (err && err_code == ERR_UNSUP) |-> $past(bus_req && !bus_we))
        else $error("unsupported error not right after a read"); // R7

    AST_TRACE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        trace_take |-> done) else $error("trace report outside done"); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && svc_req) && !(done && err))
        else $error("overlapping requests or outcomes"); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R4

endmodule

// File: tb/cp_dialog_seq_bench.sv
module cp_dialog_seq_bench;

    localparam int AW = 32;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [PW-1:0] max_polls = '0;
    logic          trace_en = 1'b0;
    logic          bus_req, bus_we, bus_sel;
    logic [AW-1:0] bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          svc_req;
    logic [13:0]   svc_prim;
    logic          svc_ack = 1'b0;
    logic          busy, done, trace_take, err;
    logic [1:0]    err_code;

    always #5 clk = ~clk;

    cp_dialog_seq #(.AW(AW), .PW(PW)) u_cp_dialog_seq (
        .clk(clk), .rst(rst), .start(start), .op_addr(op_addr),
        .max_polls(max_polls), .trace_en(trace_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .svc_req(svc_req), .svc_prim(svc_prim), .svc_ack(svc_ack),
        .busy(busy), .done(done), .trace_take(trace_take),
        .err(err), .err_code(err_code)
    );

    // Event codes of the reference model
    localparam int EV_READ  = 1;
    localparam int EV_PCW   = 2;
    localparam int EV_DONE  = 3;
    localparam int EV_DONET = 4;
    localparam int EV_EUNS  = 5;
    localparam int EV_EPOLL = 6;
    localparam int EV_SVC   = 32'h10000;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] resp_q[$];
    int          exp_q[$];
    int          bus_lat = 0, bus_wait = 0;
    int          svc_lat = 1, svc_wait = 0;
    logic [AW-1:0] cur_pc = '0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic string req_of(input int ev);
        if (ev == EV_READ)  return "R2";
        if (ev == EV_PCW)   return "R3";
        if (ev == EV_DONE)  return "R4";
        if (ev == EV_DONET) return "R9";
        if (ev == EV_EUNS)  return "R7";
        if (ev == EV_EPOLL) return "R8";
        return "R5";
    endfunction

    task automatic log_ev(input int ev);
        int e;
        if (exp_q.size() == 0) begin
            chk(1'b0, req_of(ev), ev, -1);
        end else begin
            e = exp_q.pop_front();
            chk(ev == e, req_of(e), ev, e);
        end
    endtask

    function automatic bit known_code(input logic [4:0] f);
        return f == 5'h08 || f == 5'h0C || f == 5'h0D ||
               f == 5'h10 || f == 5'h11 || f == 5'h1C;
    endfunction

    // Behavioural reference: the expected event list of one dialog.
    task automatic build_expected(input bit trc, input int maxp);
        logic [15:0] q[$];
        int reads = 0;
        int lim = (maxp == 0) ? 1 : maxp;
        logic [15:0] w;
        bit nul, again;
        q = resp_q;
        exp_q.delete();
        forever begin
            w = (q.size() > 0) ? q.pop_front() : 16'h0800;
            reads++;
            exp_q.push_back(EV_READ);
            if (!known_code(w[12:8])) begin
                exp_q.push_back(EV_EUNS);
                break;
            end
            if (w[14]) exp_q.push_back(EV_PCW);
            nul = (w[12:8] == 5'h08);
            if (!nul) exp_q.push_back(EV_SVC + int'(w[13:0]));
            again = w[15] || (trc && !nul);
            if (!again) begin
                exp_q.push_back(trc ? EV_DONET : EV_DONE);
                break;
            end
            if (reads >= lim) begin
                exp_q.push_back(EV_EPOLL);
                break;
            end
        end
    endtask

    // Coprocessor and core responders plus per-clock monitor
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(bus_req && svc_req), "R10", {bus_req, svc_req}, 0);
            chk(!(done && err), "R10", {done, err}, 0);
            if (!done) chk(!trace_take, "R9", trace_take, 0);
            if (bus_ready) begin
                bus_ready = 1'b0;
            end else if (bus_req) begin
                if (bus_wait >= bus_lat) begin
                    bus_ready = 1'b1;
                    bus_wait  = 0;
                    bus_lat   = (bus_lat + 1) % 3;
                    if (!bus_we) begin
                        log_ev(EV_READ);
                        chk(bus_sel == 1'b0, "R2", bus_sel, 0);
                        bus_rdata = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0800;
                    end else begin
                        log_ev(EV_PCW);
                        chk(bus_sel == 1'b1 && bus_wdata == cur_pc, "R3",
                            int'(bus_wdata), int'(cur_pc));
                    end
                end else begin
                    bus_wait++;
                end
            end
            if (svc_ack) begin
                svc_ack = 1'b0;
            end else if (svc_req) begin
                if (svc_wait >= svc_lat) begin
                    svc_ack  = 1'b1;
                    svc_wait = 0;
                    svc_lat  = (svc_lat + 1) % 3;
                    log_ev(EV_SVC + int'(svc_prim));
                end else begin
                    svc_wait++;
                end
            end
            if (done) log_ev(trace_take ? EV_DONET : EV_DONE);
            if (err) log_ev(err_code == 2'd1 ? EV_EUNS :
                            err_code == 2'd2 ? EV_EPOLL : 7);
        end
    end

    task automatic run(input bit trc, input int maxp, input logic [AW-1:0] pc);
        @(negedge clk);
        trace_en  = trc;
        max_polls = PW'(maxp);
        op_addr   = pc;
        cur_pc    = pc;
        build_expected(trc, maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_addr = ~pc;
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        resp_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!bus_req && !svc_req && !done && !err && !busy && !trace_take,
            "R1", {bus_req, svc_req, done, err, busy, trace_take}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_req, "R1", {busy, bus_req}, 0);

        // R4: bare release
        resp_q = '{16'h0800};
        run(1'b0, 4, 32'h0000_1000);
        // R4: busy nulls then release
        resp_q = '{16'h8800, 16'h8800, 16'h0800};
        run(1'b0, 8, 32'h0000_1004);
        // R3 R5 R6: pass-address service, come-again clear
        resp_q = '{16'h4C12};
        run(1'b0, 4, 32'hCAFE_0010);
        // R5 R6: service with come-again then release, direction bit set
        resp_q = '{16'hAD05, 16'h0800};
        run(1'b0, 4, 32'h0000_2000);
        // R3 R6: pass-address busy null then release
        resp_q = '{16'hC800, 16'h0800};
        run(1'b0, 4, 32'h1234_5678);
        // R3 R5 R6: chained services, mixed attributes
        resp_q = '{16'hD1AA, 16'h9055, 16'h7C01};
        run(1'b0, 8, 32'h0BAD_F00D);
        // R7: unsupported code
        resp_q = '{16'h0300};
        run(1'b0, 4, 32'h0000_3000);
        // R7: unsupported code with pass-address bit, error wins
        resp_q = '{16'h8800, 16'h4F00};
        run(1'b0, 4, 32'h0000_3004);
        // R8: poll limit exactly reached
        resp_q = '{16'h8800, 16'h8800, 16'h8800, 16'h8800, 16'h8800};
        run(1'b0, 3, 32'h0000_4000);
        // R8: release on the last allowed read
        resp_q = '{16'h8800, 16'h8800, 16'h0800};
        run(1'b0, 3, 32'h0000_4004);
        // R8: zero limit acts as one
        resp_q = '{16'h8800, 16'h0800};
        run(1'b0, 0, 32'h0000_4008);
        // R9: trace, immediate release
        resp_q = '{16'h0800};
        run(1'b1, 4, 32'h0000_5000);
        // R9: trace, service without come-again keeps polling
        resp_q = '{16'h1C00, 16'h8800, 16'h0800};
        run(1'b1, 8, 32'h0000_5004);
        // R9 R8: trace continuation bounded by poll limit
        resp_q = '{16'h1100, 16'h8800, 16'h0800};
        run(1'b1, 2, 32'h0000_5008);

        repeat (2) @(negedge clk);
        chk(!busy && !bus_req && !svc_req, "R1", {busy, bus_req, svc_req}, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R2 actual=%0h expected=%0h", busy, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule